// File: doc/BRIEF.md
# Single-precision to 8-bit float converter

This block converts numbers between IEEE single precision and two 8-bit floating-point formats. One format has a 4-bit exponent and a 3-bit mantissa. The other has a 5-bit exponent and a 2-bit mantissa. A single select input picks the active format for both directions in the same cycle. The encode direction takes a 32-bit float and produces an 8-bit code, rounding to nearest with ties to even. The decode direction takes an 8-bit code and produces the exactly equal 32-bit float.

The two formats handle special values differently, and one shared datapath covers both. The 4-bit-exponent format has no infinity. It clamps large magnitudes to its largest finite value and keeps a single NaN pattern for each sign. The 5-bit-exponent format follows the IEEE convention and has both infinity and NaN. Both directions handle subnormals. When rounding overflows the mantissa, the carry moves into the exponent field.

Both results are registered, so each output reflects the inputs present at the previous rising clock edge.

Top module: `fp8_convert`

## Requirements
- R1: While rst_n is low, enc_code and dec_val are zero.
- R2: Both outputs are registered with one cycle of latency. fmt_e5=0 selects the 4-bit-exponent format: sign in bit 7, exponent in bits 6:3, mantissa in bits 2:0, bias 7. fmt_e5=1 selects the 5-bit-exponent format: sign in bit 7, exponent in bits 6:2, mantissa in bits 1:0, bias 15.
- R3: The encoder rounds a normal result to the nearest representable code. On an exact tie it picks the code whose mantissa LSB is 0.
- R4: When mantissa rounding overflows, the mantissa field becomes zero and the exponent field increments. This includes a subnormal that rounds up to the smallest normal.
- R5: Magnitudes below the smallest normal encode with exponent field 0 and the nearest multiple of 2^-9 (fmt_e5=0) or 2^-16 (fmt_e5=1). Smaller magnitudes round to zero.
- R6: With fmt_e5=0, a finite magnitude above 448, or an infinite input, encodes to sign|0x7E. A non-NaN input never produces magnitude code 0x7F.
- R7: With fmt_e5=1, a magnitude above 57344, or an infinite input, encodes to sign|0x7C.
- R8: A NaN input encodes to sign|0x7F with fmt_e5=0 and to sign|0x7E with fmt_e5=1. The sign of the input is kept.
- R9: A zero input or a single-precision subnormal input encodes to 0x00 or 0x80, following its sign.
- R10: A normal code decodes to the exactly equal single-precision value.
- R11: A code with exponent field 0 and a nonzero mantissa decodes to the exactly equal, normalised single-precision value.
- R12: With fmt_e5=0, only exponent 1111 with mantissa 111 decodes to NaN, and other codes with exponent 1111 decode to finite values. With fmt_e5=1, exponent 11111 decodes to infinity when the mantissa is 0 and to NaN otherwise. A NaN output is 0x7FC00000 with the code's sign in bit 31.
- R13: Codes 0x00 and 0x80 decode to +0 and -0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_e5 | input | 1 | Format select: 0 for 4-bit exponent, 1 for 5-bit exponent |
| enc_in | input | 32 | Single-precision value to encode |
| dec_code | input | 8 | 8-bit code to decode |
| enc_code | output | 8 | Registered encoded 8-bit code |
| dec_val | output | 32 | Registered decoded single-precision value |

## Verification
The checker assumes that fmt_e5, enc_in and dec_code hold known values at every rising edge after reset, because each property compares an output with the inputs from one edge earlier. The bench changes inputs only on falling edges and always drives defined values. Most random encode inputs have exponents inside the window where both formats round, overflow or go subnormal, and the rest are uniformly random bit patterns that reach zeros, NaNs and infinities.

// File: rtl/fp8_convert.sv
module fp8_convert (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_e5,
  input  logic [31:0] enc_in,
  input  logic [7:0]  dec_code,
  output logic [7:0]  enc_code,
  output logic [31:0] dec_val
);

  localparam logic [30:0] QNAN_MAG = 31'h7FC0_0000;
  localparam logic [30:0] INF_MAG  = 31'h7F80_0000;

  logic        sgn;
  logic [7:0]  ex;
  logic [22:0] fr;
  assign {sgn, ex, fr} = enc_in;

  logic signed [9:0] te;
  logic signed [9:0] sub_sh;
  assign te     = $signed({2'b00, ex}) - 10'sd127 + (fmt_e5 ? 10'sd15 : 10'sd7);
  assign sub_sh = 10'sd1 - te;

  logic [4:0] base_sh, sh;
  assign base_sh = fmt_e5 ? 5'd21 : 5'd20;

  always_comb begin
    if (te >= 10'sd1)
      sh = base_sh;
    else if (sub_sh > 10'sd4)
      sh = 5'd25;
    else
      sh = base_sh + sub_sh[4:0];
  end

  logic [24:0] sig, low_mask;
  logic [8:0]  q;
  logic        guard, sticky, rnd_up;
  assign sig      = {2'b01, fr};
  assign q        = 9'(sig >> sh);
  assign low_mask = (25'd1 << (sh - 5'd1)) - 25'd1;
  assign guard    = sig[sh - 5'd1];
  assign sticky   = |(sig & low_mask);
  assign rnd_up   = guard & (sticky | q[0]);

  logic [8:0] exp_part, mag;
  assign exp_part = fmt_e5 ? {te[6:0] - 7'd1, 2'b00} : {te[5:0] - 6'd1, 3'b000};
  assign mag      = ((te >= 10'sd1) ? exp_part + q : q) + {8'd0, rnd_up};

  logic big4, big5;
  assign big4 = (te > 10'sd15) | (mag > 9'h07E);
  assign big5 = (te > 10'sd30) | ((te == 10'sd30) & (&fr[22:21]) & (|fr[20:0]));

  logic [6:0] enc_mag;
  always_comb begin
    if (ex == 8'hFF) begin
      if (fr != 23'd0) enc_mag = fmt_e5 ? 7'h7E : 7'h7F;
      else             enc_mag = fmt_e5 ? 7'h7C : 7'h7E;
    end else if (ex == 8'h00)
      enc_mag = 7'h00;
    else if (fmt_e5)
      enc_mag = big5 ? 7'h7C : mag[6:0];
    else
      enc_mag = big4 ? 7'h7E : mag[6:0];
  end

  logic [3:0] d4e;
  logic [2:0] d4m;
  logic [4:0] d5e;
  logic [1:0] d5m;
  assign d4e = dec_code[6:3];
  assign d4m = dec_code[2:0];
  assign d5e = dec_code[6:2];
  assign d5m = dec_code[1:0];

  logic [30:0] dmag4, dmag5;

  always_comb begin
    if (d4e == 4'hF && d4m == 3'h7)
      dmag4 = QNAN_MAG;
    else if (d4e != 4'h0)
      dmag4 = {{4'd0, d4e} + 8'd120, d4m, 20'd0};
    else if (d4m[2])
      dmag4 = {8'd120, d4m[1:0], 21'd0};
    else if (d4m[1])
      dmag4 = {8'd119, d4m[0], 22'd0};
    else if (d4m[0])
      dmag4 = {8'd118, 23'd0};
    else
      dmag4 = 31'd0;
  end

  always_comb begin
    if (d5e == 5'h1F)
      dmag5 = (d5m == 2'd0) ? INF_MAG : QNAN_MAG;
    else if (d5e != 5'h0)
      dmag5 = {{3'd0, d5e} + 8'd112, d5m, 21'd0};
    else if (d5m[1])
      dmag5 = {8'd112, d5m[0], 22'd0};
    else if (d5m[0])
      dmag5 = {8'd111, 23'd0};
    else
      dmag5 = 31'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_code <= 8'd0;
      dec_val  <= 32'd0;
    end else begin
      enc_code <= {sgn, enc_mag};
      dec_val  <= {dec_code[7], fmt_e5 ? dmag5 : dmag4};
    end
  end

endmodule

// File: rtl/fp8_convert_chk.sv
module fp8_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fmt_e5,
  input logic [31:0] enc_in,
  input logic [7:0]  dec_code,
  input logic [7:0]  enc_code,
  input logic [31:0] dec_val
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R8
  enc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> enc_code[7] == $past(enc_in[31]));

  // R6
  e4_no_nan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(fmt_e5) && !($past(enc_in[30:23]) == 8'hFF && $past(enc_in[22:0]) != 23'd0))
      |-> enc_code[6:0] != 7'h7F);

  // R7
  e5_inf_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(fmt_e5) && $past(enc_in[30:0]) == 31'h7F80_0000) |-> enc_code[6:0] == 7'h7C);

  // R9
  zero_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(enc_in[30:23]) == 8'h00) |-> enc_code[6:0] == 7'h00);

  // R12
  e4_no_inf_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(fmt_e5)) |-> dec_val[30:0] != 31'h7F80_0000);

  // R13
  dec_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> dec_val[31] == $past(dec_code[7]));

endmodule

bind fp8_convert fp8_convert_chk u_fp8_convert_chk (
  .clk(clk), .rst_n(rst_n), .fmt_e5(fmt_e5), .enc_in(enc_in),
  .dec_code(dec_code), .enc_code(enc_code), .dec_val(dec_val));

// File: tb/fp8_convert_bench.sv
`timescale 1ns/1ps
module fp8_convert_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_e5 = 1'b0;
  logic [31:0] enc_in = 32'd0;
  logic [7:0]  dec_code = 8'd0;
  logic [7:0]  enc_code;
  logic [31:0] dec_val;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fp8_convert u_fp8_convert (
    .clk(clk), .rst_n(rst_n), .fmt_e5(fmt_e5), .enc_in(enc_in),
    .dec_code(dec_code), .enc_code(enc_code), .dec_val(dec_val));

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) repeat (n) r = r * 2.0;
    else        repeat (-n) r = r / 2.0;
    return r;
  endfunction

  function automatic real f32_mag(input logic [31:0] x);
    if (x[30:23] == 8'd0) return real'(x[22:0]) * pow2(-149);
    return (real'(x[22:0]) + 8388608.0) * pow2(int'(x[30:23]) - 150);
  endfunction

  function automatic real code_mag(input logic [6:0] c, input bit e5);
    if (!e5) begin
      if (c[6:3] == 4'd0) return real'(c[2:0]) * pow2(-9);
      return (8.0 + real'(c[2:0])) * pow2(int'(c[6:3]) - 10);
    end
    if (c[6:2] == 5'd0) return real'(c[1:0]) * pow2(-16);
    return (4.0 + real'(c[1:0])) * pow2(int'(c[6:2]) - 17);
  endfunction

  function automatic logic [7:0] ref_enc(input logic [31:0] x, input bit e5);
    logic s;
    real v, lim, bd, d;
    logic [6:0] best, top;
    s = x[31];
    if (x[30:23] == 8'hFF) begin
      if (x[22:0] != 23'd0) return e5 ? {s, 7'h7E} : {s, 7'h7F};
      return e5 ? {s, 7'h7C} : {s, 7'h7E};
    end
    v   = f32_mag(x);
    lim = e5 ? 57344.0 : 448.0;
    if (v > lim) return e5 ? {s, 7'h7C} : {s, 7'h7E};
    top  = e5 ? 7'h7B : 7'h7E;
    best = 7'd0;
    bd   = v;
    for (int c = 1; c <= int'(top); c++) begin
      d = v - code_mag(7'(c), e5);
      if (d < 0.0) d = -d;
      if (d < bd || (d == bd && c % 2 == 0)) begin
        best = 7'(c);
        bd   = d;
      end
    end
    return {s, best};
  endfunction

  function automatic logic [31:0] ref_dec(input logic [7:0] c, input bit e5);
    logic s;
    real m;
    int e;
    longint frac;
    s = c[7];
    if (!e5 && c[6:0] == 7'h7F) return {s, 31'h7FC0_0000};
    if (e5 && c[6:2] == 5'h1F) return (c[1:0] == 2'd0) ? {s, 31'h7F80_0000} : {s, 31'h7FC0_0000};
    m = code_mag(c[6:0], e5);
    if (m == 0.0) return {s, 31'd0};
    e = 0;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0) begin m = m * 2.0; e--; end
    frac = $rtoi((m - 1.0) * 8388608.0);
    return {s, 8'(e + 127), 23'(frac)};
  endfunction

  function automatic string enc_tag(input logic [31:0] x, input bit e5, input logic [7:0] r);
    if (x[30:23] == 8'hFF && x[22:0] != 23'd0) return "R8";
    if (x[30:23] == 8'hFF) return e5 ? "R7" : "R6";
    if (f32_mag(x) > (e5 ? 57344.0 : 448.0)) return e5 ? "R7" : "R6";
    if (x[30:23] == 8'h00) return "R9";
    if (e5 ? (r[6:2] == 5'd0) : (r[6:3] == 4'd0)) return "R5";
    return "R3";
  endfunction

  function automatic string dec_tag(input logic [7:0] c, input bit e5);
    if (e5 ? (c[6:2] == 5'h1F) : (c[6:3] == 4'hF)) return "R12";
    if (c[6:0] == 7'd0) return "R13";
    if (e5 ? (c[6:2] == 5'd0) : (c[6:3] == 4'd0)) return "R11";
    return "R10";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input bit e5, input logic [31:0] x, input logic [7:0] c,
                      input string et, input string dt);
    logic [7:0]  ee;
    logic [31:0] de;
    @(negedge clk);
    fmt_e5 = e5; enc_in = x; dec_code = c;
    @(negedge clk);
    ee = ref_enc(x, e5);
    de = ref_dec(c, e5);
    check((et == "") ? enc_tag(x, e5, ee) : et, {24'd0, enc_code}, {24'd0, ee});
    check((dt == "") ? dec_tag(c, e5) : dt, dec_val, de);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fmt_e5 = 1'b0; enc_in = 32'h3F80_0000; dec_code = 8'h38;
    repeat (3) @(negedge clk);
    check("R1", {24'd0, enc_code}, 32'd0);
    check("R1", dec_val, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: one cycle after release, 1.0 in both directions with fmt_e5=0
    check("R2", {24'd0, enc_code}, 32'h38);
    check("R2", dec_val, 32'h3F80_0000);

    step(1'b1, 32'h3F80_0000, 8'h3C, "R2", "R2");
    step(1'b0, 32'h3F88_0000, 8'h39, "R3", "R10"); // tie, even stays
    step(1'b0, 32'h3F98_0000, 8'hB9, "R3", "R10"); // tie, rounds up to even
    step(1'b0, 32'h3FF8_0000, 8'h01, "R4", "R11"); // mantissa carry to 2.0
    step(1'b1, 32'h3FF0_0000, 8'h03, "R4", "R11");
    step(1'b0, 32'h3C70_0000, 8'h06, "R4", "R11"); // subnormal rounds to min normal
    step(1'b0, 32'h3B00_0000, 8'h7F, "R5", "R12");
    step(1'b0, 32'h3A80_0000, 8'hFF, "R5", "R12"); // half of min subnormal -> 0
    step(1'b0, 32'h3AC0_0000, 8'h78, "R5", "R12"); // exponent 1111 finite
    step(1'b1, 32'h3780_0000, 8'h7C, "R5", "R12");
    step(1'b1, 32'h3700_0001, 8'hFD, "R5", "R12");
    step(1'b0, 32'h447A_0000, 8'h7E, "R6", "R10"); // 1000 -> 448
    step(1'b0, 32'h43E8_0000, 8'h77, "R6", "R10"); // 464 -> 448
    step(1'b0, 32'hFF80_0000, 8'h80, "R6", "R13");
    step(1'b1, 32'h4760_0000, 8'h00, "R7", "R13"); // 57344 finite
    step(1'b1, 32'h4760_0800, 8'h7B, "R7", "R10"); // just above -> inf
    step(1'b1, 32'h7F80_0000, 8'h80, "R7", "R13");
    step(1'b0, 32'h7FC0_0001, 8'h00, "R8", "R13");
    step(1'b1, 32'hFFC0_0000, 8'h00, "R8", "R13");
    step(1'b0, 32'h8000_0000, 8'h00, "R9", "R13");
    step(1'b1, 32'h0000_0001, 8'h80, "R9", "R13");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x;
      bit e5;
      x  = $urandom;
      e5 = 1'($urandom);
      if ($urandom_range(0, 7) != 0) x[30:23] = 8'(100 + $urandom_range(0, 45));
      step(e5, x, 8'($urandom), "", "");
    end

    summary();
    $finish;
  end

endmodule